// File: doc/BRIEF.md
# Four-Round Add-Rotate-XOR Box

This block mixes one 64-bit branch, held as two 32-bit halves `x` and `y`, under a 32-bit round constant. It applies four add-rotate-XOR rounds in a fixed order. Each round adds a rotated `y` into `x` and XORs a rotated copy of the new `x` into `y`. It then XORs the constant into `x`. The rotation amounts change from round to round, and the constant goes into `x` at the end of every round, not only once.

A parameter selects one of two builds. The iterative build shares one round unit and runs one round per clock, with a start/done handshake. The unrolled build chains four round units and returns a result one cycle after each start. The caller chooses the constant and schedules the branches.

Top module: `arx4_box`

## Requirements
- R1: One round computes `x1 = x + rotr(y, a)` modulo 2^32, then `y' = y ^ rotr(x1, b)` using that new `x1`, then `x' = x1 ^ c`. Here `rotr` is a 32-bit right rotation.
- R2: Round index 0 uses the rotation pair a=31, b=24.
- R3: Round index 1 uses the rotation pair a=17, b=17.
- R4: Round index 2 uses the rotation pair a=0, b=31.
- R5: Round index 3 uses the rotation pair a=24, b=16.
- R6: In the iterative build (UNROLL=0), a start sampled while idle makes `done` high for exactly one cycle, after the fourth rising edge counted from the edge that sampled start. The outputs then equal rounds 0, 1, 2 and 3 applied in that order to the inputs sampled with start.
- R7: In the iterative build, `x_out` and `y_out` stay unchanged after `done` until the next accepted start.
- R8: In the iterative build, start is ignored while a computation is in progress. Neither the result nor the timing of `done` changes, and no extra `done` follows.
- R9: A synchronous reset clears `done`, zeroes the outputs and abandons any computation in progress, so no `done` follows it.
- R10: In the unrolled build (UNROLL=1), every start is accepted. `done` is high on the cycle after the start and carries the four-round result, including for starts on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation on `x_in`, `y_in`, `k_in` |
| x_in | input | WORD_W | Input half `x` |
| y_in | input | WORD_W | Input half `y` |
| k_in | input | WORD_W | Round constant |
| x_out | output | WORD_W | Result half `x` |
| y_out | output | WORD_W | Result half `y` |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds two instances at WORD_W=32. With UNROLL=0 it reaches the shared-round sequencing: the four-edge latency, holding the result, ignoring start while busy, and reset during a computation. With UNROLL=1 it reaches the chained datapath under back-to-back starts. Four stand-alone round units, one tied to each index, isolate each rotation pair. This lets a wrong amount in a single round be traced to its own requirement.

// File: rtl/arx_pkg.sv
package arx_pkg;
   localparam int N_ROUNDS = 4;
   localparam int IDX_W    = $clog2(N_ROUNDS);
   localparam int ROT_W    = 5;

   typedef struct packed {
      logic [ROT_W-1:0] add_rot;
      logic [ROT_W-1:0] xor_rot;
   } rot_pair_t;

   // Fixed rotation schedule, order is behaviour (R2..R5)
   function automatic rot_pair_t rot_pair(input logic [IDX_W-1:0] idx);
      rot_pair_t p;
      case (idx)
         2'd0:    begin p.add_rot = 5'd31; p.xor_rot = 5'd24; end
         2'd1:    begin p.add_rot = 5'd17; p.xor_rot = 5'd17; end
         2'd2:    begin p.add_rot = 5'd0;  p.xor_rot = 5'd31; end
         default: begin p.add_rot = 5'd24; p.xor_rot = 5'd16; end
      endcase
      return p;
   endfunction
endpackage

// File: rtl/arx_round.sv
module arx_round #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0]          xi,
   input  logic [WORD_W-1:0]          yi,
   input  logic [WORD_W-1:0]          ci,
   input  logic [arx_pkg::IDX_W-1:0]  idx,
   output logic [WORD_W-1:0]          xo,
   output logic [WORD_W-1:0]          yo
);
   import arx_pkg::*;

   function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v,
                                              input logic [ROT_W-1:0] s);
      logic [2*WORD_W-1:0] dbl;
      dbl = {v, v} >> s;
      return dbl[WORD_W-1:0];
   endfunction

   rot_pair_t         pair;
   logic [WORD_W-1:0] x_sum;

   always_comb begin
      pair  = rot_pair(idx);
      x_sum = xi + rotr(yi, pair.add_rot);
      yo    = yi ^ rotr(x_sum, pair.xor_rot);
      xo    = x_sum ^ ci;
   end
endmodule

// File: rtl/arx_iter_core.sv
module arx_iter_core #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] x_in,
   input  logic [WORD_W-1:0] y_in,
   input  logic [WORD_W-1:0] k_in,
   output logic [WORD_W-1:0] x_out,
   output logic [WORD_W-1:0] y_out,
   output logic              done
);
   import arx_pkg::*;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ROUNDS - 1);

   logic [WORD_W-1:0] x_q, y_q, k_q, src_x, src_y, src_k, nx, ny;
   logic [IDX_W-1:0]  rnd_q, cur_idx;
   logic              busy_q, done_q;

   always_comb begin
      src_x   = busy_q ? x_q   : x_in;
      src_y   = busy_q ? y_q   : y_in;
      src_k   = busy_q ? k_q   : k_in;
      cur_idx = busy_q ? rnd_q : '0;
   end

   arx_round #(.WORD_W(WORD_W)) u_round (
      .xi(src_x), .yi(src_y), .ci(src_k), .idx(cur_idx), .xo(nx), .yo(ny)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0; y_q <= '0; k_q <= '0;
         rnd_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start) begin
            x_q <= nx; y_q <= ny; k_q <= k_in;
            rnd_q <= IDX_W'(1); busy_q <= 1'b1;
         end else if (busy_q) begin
            x_q <= nx; y_q <= ny;
            rnd_q <= rnd_q + 1'b1;
            if (rnd_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign x_out = x_q;
   assign y_out = y_q;
   assign done  = done_q;

   // R6
   accept_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !busy_q) |=> (busy_q && rnd_q == IDX_W'(1)));
   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |-> (!busy_q && $past(busy_q) && $past(rnd_q) == LAST));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_q && !start) |=> ($stable(x_q) && $stable(y_q)));
   // R8
   busy_step_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && rnd_q != LAST) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1 && $stable(k_q)));
endmodule

// File: rtl/arx_unrolled_core.sv
module arx_unrolled_core #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] x_in,
   input  logic [WORD_W-1:0] y_in,
   input  logic [WORD_W-1:0] k_in,
   output logic [WORD_W-1:0] x_out,
   output logic [WORD_W-1:0] y_out,
   output logic              done
);
   import arx_pkg::*;

   logic [WORD_W-1:0] xs [N_ROUNDS+1];
   logic [WORD_W-1:0] ys [N_ROUNDS+1];
   logic [WORD_W-1:0] x_q, y_q;
   logic              done_q;

   assign xs[0] = x_in;
   assign ys[0] = y_in;

   for (genvar g = 0; g < N_ROUNDS; g++) begin : g_stage
      arx_round #(.WORD_W(WORD_W)) u_round (
         .xi(xs[g]), .yi(ys[g]), .ci(k_in), .idx(IDX_W'(g)),
         .xo(xs[g+1]), .yo(ys[g+1])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0; y_q <= '0; done_q <= 1'b0;
      end else begin
         done_q <= start;
         if (start) begin
            x_q <= xs[N_ROUNDS];
            y_q <= ys[N_ROUNDS];
         end
      end
   end

   assign x_out = x_q;
   assign y_out = y_q;
   assign done  = done_q;

   // R10
   strobe_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> done_q);
   // R10
   no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> (!done_q && $stable(x_q) && $stable(y_q)));
endmodule

// File: rtl/arx4_box.sv
module arx4_box #(
   parameter int WORD_W = 32,
   parameter bit UNROLL = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] x_in,
   input  logic [WORD_W-1:0] y_in,
   input  logic [WORD_W-1:0] k_in,
   output logic [WORD_W-1:0] x_out,
   output logic [WORD_W-1:0] y_out,
   output logic              done
);
   if (WORD_W != 32) begin : g_bad_width
      $error("arx4_box: rotation schedule is defined for WORD_W == 32 only");
   end

   if (UNROLL) begin : g_unrolled
      arx_unrolled_core #(.WORD_W(WORD_W)) u_core (
         .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
         .k_in(k_in), .x_out(x_out), .y_out(y_out), .done(done)
      );
   end else begin : g_iterative
      arx_iter_core #(.WORD_W(WORD_W)) u_core (
         .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
         .k_in(k_in), .x_out(x_out), .y_out(y_out), .done(done)
      );
   end

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!done && x_out == '0 && y_out == '0));
endmodule

// File: tb/arx4_box_bench.sv
module arx4_box_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic         st_i = 0, st_u = 0;
   logic [W-1:0] xi_i = 0, yi_i = 0, ki_i = 0, xi_u = 0, yi_u = 0, ki_u = 0;
   logic [W-1:0] xo_i, yo_i, xo_u, yo_u;
   logic         dn_i, dn_u;

   arx4_box #(.WORD_W(W), .UNROLL(1'b0)) u_arx4_box (
      .clk(clk), .rst(rst), .start(st_i), .x_in(xi_i), .y_in(yi_i), .k_in(ki_i),
      .x_out(xo_i), .y_out(yo_i), .done(dn_i));
   arx4_box #(.WORD_W(W), .UNROLL(1'b1)) u_arx4_box_unr (
      .clk(clk), .rst(rst), .start(st_u), .x_in(xi_u), .y_in(yi_u), .k_in(ki_u),
      .x_out(xo_u), .y_out(yo_u), .done(dn_u));

   // single-round units, one per index
   logic [W-1:0] rx = 0, ry = 0, rk = 0;
   logic [W-1:0] rxo [4];
   logic [W-1:0] ryo [4];
   for (genvar g = 0; g < 4; g++) begin : g_rnd
      arx_round #(.WORD_W(W)) u_r (.xi(rx), .yi(ry), .ci(rk), .idx(2'(g)),
                                   .xo(rxo[g]), .yo(ryo[g]));
   end

   function automatic logic [W-1:0] rr(input logic [W-1:0] v, input int s);
      if (s == 0) return v;
      return (v >> s) | (v << (W - s));
   endfunction

   function automatic logic [63:0] ref_round(input logic [W-1:0] x, y, c,
                                             input int a, b);
      logic [W-1:0] xn, yn;
      xn = x + rr(y, a);
      yn = y ^ rr(xn, b);
      return {xn ^ c, yn};
   endfunction

   function automatic logic [63:0] ref4(input logic [W-1:0] x, y, c);
      logic [63:0] s;
      s = ref_round(x, y, c, 31, 24);
      s = ref_round(s[63:32], s[31:0], c, 17, 17);
      s = ref_round(s[63:32], s[31:0], c, 0, 31);
      s = ref_round(s[63:32], s[31:0], c, 24, 16);
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         finish_run();
      end
   end

   // scoreboards
   logic [63:0] exp_i[$];
   logic [63:0] exp_u[$];

   always @(negedge clk) begin
      if (!rst && dn_i) begin
         if (exp_i.size() == 0) chk(1'b0, "R8 unexpected done", {xo_i, yo_i}, 64'h0);
         else begin
            logic [63:0] e;
            e = exp_i.pop_front();
            chk({xo_i, yo_i} == e, "R6 iterative result", {xo_i, yo_i}, e);
         end
      end
      if (!rst && dn_u) begin
         if (exp_u.size() == 0) chk(1'b0, "R10 unexpected done", {xo_u, yo_u}, 64'h0);
         else begin
            logic [63:0] e;
            e = exp_u.pop_front();
            chk({xo_u, yo_u} == e, "R10 unrolled result", {xo_u, yo_u}, e);
         end
      end
   end

   // drives a start on the iterative build and checks done timing (R6)
   task automatic run_iter(input logic [W-1:0] x, y, c, input bit poke_busy);
      @(negedge clk);
      xi_i = x; yi_i = y; ki_i = c; st_i = 1'b1;
      exp_i.push_back(ref4(x, y, c));
      @(negedge clk);
      st_i = 1'b0;
      chk(dn_i == 1'b0, "R6 no done after edge 1", {63'h0, dn_i}, 64'h0);
      if (poke_busy) begin
         xi_i = ~x; yi_i = 32'h1234_5678; ki_i = ~c; st_i = 1'b1;  // R8
      end
      @(negedge clk);
      st_i = 1'b0;
      chk(dn_i == 1'b0, "R6 no done after edge 2", {63'h0, dn_i}, 64'h0);
      @(negedge clk);
      chk(dn_i == 1'b0, "R6 no done after edge 3", {63'h0, dn_i}, 64'h0);
      @(negedge clk);
      chk(dn_i == 1'b1, "R6 done after edge 4", {63'h0, dn_i}, 64'h1);
      @(negedge clk);
      chk(dn_i == 1'b0, "R6 done lasts one cycle", {63'h0, dn_i}, 64'h0);
   endtask

   initial begin
      logic [63:0] e;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(dn_i == 0 && xo_i == 0 && yo_i == 0, "R9 reset state", {xo_i, yo_i}, 64'h0);
      chk(dn_u == 0 && xo_u == 0 && yo_u == 0, "R9 reset state unrolled", {xo_u, yo_u}, 64'h0);
      rst = 1'b0;

      // R1..R5 single rounds per index
      for (int v = 0; v < 3; v++) begin
         rx = (v == 0) ? 32'h0000_0001 : (v == 1) ? 32'h8000_0000 : 32'hdead_beef;
         ry = (v == 0) ? 32'h0000_0001 : (v == 1) ? 32'h0f0f_0001 : 32'h0123_4567;
         rk = (v == 2) ? 32'h9e37_79b9 : 32'h0;
         #1;
         e = ref_round(rx, ry, rk, 31, 24);
         chk({rxo[0], ryo[0]} == e, "R2 R1 round idx0", {rxo[0], ryo[0]}, e);
         e = ref_round(rx, ry, rk, 17, 17);
         chk({rxo[1], ryo[1]} == e, "R3 R1 round idx1", {rxo[1], ryo[1]}, e);
         e = ref_round(rx, ry, rk, 0, 31);
         chk({rxo[2], ryo[2]} == e, "R4 R1 round idx2", {rxo[2], ryo[2]}, e);
         e = ref_round(rx, ry, rk, 24, 16);
         chk({rxo[3], ryo[3]} == e, "R5 R1 round idx3", {rxo[3], ryo[3]}, e);
      end

      // R6 several patterns, including all-zero
      run_iter(32'h0, 32'h0, 32'h0, 1'b0);
      run_iter(32'h0000_0001, 32'h0, 32'h0, 1'b0);
      run_iter(32'hffff_ffff, 32'hffff_ffff, 32'h9e37_79b9, 1'b0);
      run_iter(32'h0123_4567, 32'h89ab_cdef, 32'h5a5a_a5a5, 1'b0);

      // R7 hold after done
      e = ref4(32'h0123_4567, 32'h89ab_cdef, 32'h5a5a_a5a5);
      repeat (3) @(negedge clk);
      chk({xo_i, yo_i} == e, "R7 outputs held", {xo_i, yo_i}, e);

      // R8 start while busy ignored
      run_iter(32'hcafe_f00d, 32'h1357_9bdf, 32'h0bad_c0de, 1'b1);
      repeat (3) @(negedge clk);
      chk(dn_i == 1'b0, "R8 no extra done", {63'h0, dn_i}, 64'h0);
      e = ref4(32'hcafe_f00d, 32'h1357_9bdf, 32'h0bad_c0de);
      chk({xo_i, yo_i} == e, "R8 result unchanged", {xo_i, yo_i}, e);

      // R9 reset mid computation
      @(negedge clk);
      xi_i = 32'h7; yi_i = 32'h9; ki_i = 32'h3; st_i = 1'b1;
      @(negedge clk);
      st_i = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(xo_i == 0 && yo_i == 0 && dn_i == 0, "R9 reset clears", {xo_i, yo_i}, 64'h0);
      repeat (5) @(negedge clk);
      chk(dn_i == 1'b0, "R9 no done after reset", {63'h0, dn_i}, 64'h0);

      // R10 unrolled, back-to-back starts
      @(negedge clk);
      xi_u = 32'h1; yi_u = 32'h2; ki_u = 32'h3; st_u = 1'b1;
      exp_u.push_back(ref4(32'h1, 32'h2, 32'h3));
      @(negedge clk);
      chk(dn_u == 1'b1, "R10 done one cycle after start", {63'h0, dn_u}, 64'h1);
      xi_u = 32'hffff_0000; yi_u = 32'h00ff_ff00; ki_u = 32'h9e37_79b9;
      exp_u.push_back(ref4(32'hffff_0000, 32'h00ff_ff00, 32'h9e37_79b9));
      @(negedge clk);
      st_u = 1'b0;
      chk(dn_u == 1'b1, "R10 second done", {63'h0, dn_u}, 64'h1);
      @(negedge clk);
      chk(dn_u == 1'b0, "R10 done drops", {63'h0, dn_u}, 64'h0);

      repeat (2) @(negedge clk);
      chk(exp_i.size() == 0, "R6 all results seen", 64'(exp_i.size()), 64'h0);
      chk(exp_u.size() == 0, "R10 all results seen", 64'(exp_u.size()), 64'h0);
      finish_run();
   end
endmodule